// File: doc/BRIEF.md
# Platform Power-On Sequencer

This block is a state machine that lives in the always-on standby domain and runs from the 32.768 kHz reference clock. Without that clock nothing advances, so the block simply holds its last state. It watches an active-low power button. When it accepts a press, it sends a fixed-length active-low event pulse to the chipset and switches on the standby rail.

The sequencer then waits until the chipset releases both of its active-low sleep-state signals. After that it switches on the suspend, main and core-regulator rails one stage at a time. Once every rail reports good, it releases three power-OK outputs one after another, in the order south bridge, north bridge, then CPU.

A rail that loses power-good while the platform is up removes all power immediately. A handshake that does not arrive within a timeout returns the block to standby. A second press, or the deep-sleep signal going low, starts an orderly shutdown: the power-OK outputs drop first, then the rails go off in the reverse of their enable order.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Out of reset, all rail enables and all power-OK outputs are low and the event output is high.
- R2: After a two-stage synchronizer, the button is accepted as a press only if it reads low on at least MIN_LOW (2) consecutive synchronized samples. A press driven low for one sampled cycle is ignored. Once accepted, the block acts on the fourth rising edge after the input first falls.
- R3: Every accepted press drives the event output low for exactly EVT_LEN (4) cycles, starting on the same edge where the sequencer acts on the press.
- R4: A press while off sets rail bit 0 (standby). The sequencer advances only when both sleep inputs are high; one released input alone leaves the rails unchanged.
- R5: After the release is sampled, rail bit 1 (suspend), bit 2 (main) and bit 3 (core) turn on in that order. The first comes RAIL_GAP cycles after the sampling edge and each later one RAIL_GAP cycles after the previous. At every cycle the set rails are a run of ones starting at bit 0.
- R6: With all rails on, the first edge that samples every power-good input high starts the count. Power-OK bit 0 (south) rises PG_DLY edges later, bit 1 (north) POK_GAP edges after bit 0, and bit 2 (CPU) POK_GAP edges after bit 1. A higher bit is never high while a lower bit is low.
- R7: While powered up, any power-good input sampled low clears every rail enable and every power-OK output on that edge.
- R8: If the sleep release, or all power-good inputs high, has not arrived TIMEOUT edges after entering the wait, every rail enable is cleared.
- R9: While powered up, an accepted press or the deep-sleep input sampled low clears all power-OK outputs on that edge. The rails then turn off from the highest set bit down, one every RAIL_GAP cycles.
- R10: No power-OK output is ever high unless every rail enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz standby reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_n_i | input | 1 | Raw active-low power button |
| slp_lite_n_i | input | 1 | Chipset shallow sleep-state signal, active low |
| slp_deep_n_i | input | 1 | Chipset deep sleep-state signal, active low |
| pgood_i | input | NUM_PG | Per-rail power-good feedback |
| btn_evt_n_o | output | 1 | Forwarded active-low button event pulse |
| rail_en_o | output | NUM_RAILS | Rail enables: bit 0 standby, 1 suspend, 2 main, 3 core |
| pok_o | output | NUM_POK | Power-OK: bit 0 south bridge, 1 north bridge, 2 CPU |

## Verification
The bound checker watches several invariants on every cycle:
- the rail enables always form a contiguous run from bit 0;
- power-OK is thermometer-ordered and never high without all rails on;
- losing power-good while up empties both vectors on the next edge;
- deep sleep low clears power-OK while the rails stay on;
- the standby rail only rises together with an event pulse.

Only the bench scenarios can show the exact cycle counts. These cover press acceptance and glitch rejection, the event pulse length, the ramp spacing, the staggered power-OK delays, both timeout windows and the reverse-order shutdown spacing. Randomized power-good drops at arbitrary points in the power-OK stagger are also checked by the bench.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_WAIT_SLP,
      ST_RAMP,
      ST_WAIT_PG,
      ST_ON,
      ST_SHUT
   } seq_state_t;

endpackage

// File: rtl/pwr_seq_btn.sv
// Button synchronizer, low-time qualifier and event pulse stretcher.
module pwr_seq_btn #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 2,
   parameter int EVT_LEN     = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_n_i,
   output logic press_o,
   output logic evt_n_o
);

   localparam int LOW_W = $clog2(MIN_LOW + 1);
   localparam int EVT_W = $clog2(EVT_LEN + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [LOW_W-1:0]       low_cnt_q;
   logic [EVT_W-1:0]       evt_cnt_q;
   logic                   btn_lvl;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n_i};
   end

   assign btn_lvl = sync_q[SYNC_STAGES-1];

   // Counts synchronized low samples, saturating at MIN_LOW.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             low_cnt_q <= '0;
      else if (btn_lvl)                        low_cnt_q <= '0;
      else if (low_cnt_q != LOW_W'(MIN_LOW))   low_cnt_q <= low_cnt_q + 1'b1;
   end

   // One press per low period, on its MIN_LOW-th low sample.
   assign press_o = !btn_lvl && (low_cnt_q == LOW_W'(MIN_LOW - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 evt_cnt_q <= '0;
      else if (press_o)            evt_cnt_q <= EVT_W'(EVT_LEN);
      else if (evt_cnt_q != '0)    evt_cnt_q <= evt_cnt_q - 1'b1;
   end

   assign evt_n_o = (evt_cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Handshake-gated rail sequencer with timeout and reverse-order shutdown.
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int NUM_RAILS = 4,
   parameter int RAIL_GAP  = 4,
   parameter int TIMEOUT   = 32768
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 press_i,
   input  logic                 slp_lite_n_i,
   input  logic                 slp_deep_n_i,
   input  logic                 pg_all_i,
   output logic [NUM_RAILS-1:0] rails_o,
   output logic                 on_o
);

   localparam int STEP_W = (RAIL_GAP > 1) ? $clog2(RAIL_GAP) : 1;
   localparam int TMR_W  = $clog2(TIMEOUT);
   localparam logic [STEP_W-1:0]    STEP_LAST = STEP_W'(RAIL_GAP - 1);
   localparam logic [TMR_W-1:0]     TMR_LAST  = TMR_W'(TIMEOUT - 1);
   localparam logic [NUM_RAILS-1:0] RAIL_BASE = {{(NUM_RAILS-1){1'b0}}, 1'b1};

   seq_state_t           state_q;
   logic [NUM_RAILS-1:0] rails_q;
   logic [STEP_W-1:0]    step_q;
   logic [TMR_W-1:0]     tmr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_OFF;
         rails_q <= '0;
         step_q  <= '0;
         tmr_q   <= '0;
      end else begin
         case (state_q)
            ST_OFF: begin
               if (press_i) begin
                  state_q <= ST_WAIT_SLP;
                  rails_q <= RAIL_BASE;
                  tmr_q   <= '0;
               end
            end
            ST_WAIT_SLP: begin
               if (press_i) begin
                  state_q <= ST_SHUT;
                  step_q  <= '0;
               end else if (slp_lite_n_i && slp_deep_n_i) begin
                  state_q <= ST_RAMP;
                  step_q  <= '0;
               end else if (tmr_q == TMR_LAST) begin
                  state_q <= ST_OFF;
                  rails_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_RAMP: begin
               if (press_i) begin
                  state_q <= ST_SHUT;
                  step_q  <= '0;
               end else if (step_q == STEP_LAST) begin
                  step_q  <= '0;
                  rails_q <= {rails_q[NUM_RAILS-2:0], 1'b1};
                  if (rails_q[NUM_RAILS-2]) begin
                     state_q <= ST_WAIT_PG;
                     tmr_q   <= '0;
                  end
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            ST_WAIT_PG: begin
               if (press_i) begin
                  state_q <= ST_SHUT;
                  step_q  <= '0;
               end else if (pg_all_i) begin
                  state_q <= ST_ON;
               end else if (tmr_q == TMR_LAST) begin
                  state_q <= ST_OFF;
                  rails_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_ON: begin
               if (!pg_all_i) begin
                  state_q <= ST_OFF;
                  rails_q <= '0;
               end else if (press_i || !slp_deep_n_i) begin
                  state_q <= ST_SHUT;
                  step_q  <= '0;
               end
            end
            ST_SHUT: begin
               if (step_q == STEP_LAST) begin
                  step_q  <= '0;
                  rails_q <= rails_q >> 1;
                  if (!rails_q[1]) state_q <= ST_OFF;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_OFF;
               rails_q <= '0;
            end
         endcase
      end
   end

   assign rails_o = rails_q;
   assign on_o    = (state_q == ST_ON);

endmodule

// File: rtl/pwr_seq_pok.sv
// Staggered power-OK generator: one comparator per output on a shared counter.
module pwr_seq_pok #(
   parameter int NUM_POK = 3,
   parameter int PG_DLY  = 64,
   parameter int POK_GAP = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   output logic [NUM_POK-1:0] pok_o
);

   localparam int LAST  = PG_DLY + (NUM_POK - 1) * POK_GAP;
   localparam int CNT_W = (LAST > 0) ? $clog2(LAST + 1) : 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cnt_q <= '0;
      else if (!run_i)                   cnt_q <= '0;
      else if (cnt_q != CNT_W'(LAST))    cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_POK; i++) begin : g_pok
      assign pok_o[i] = run_i && (cnt_q >= CNT_W'(PG_DLY + i * POK_GAP));
   end

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top level: button front end, rail sequencer, power-OK stagger.
module pwr_seq_ctrl #(
   parameter int NUM_PG      = 4,
   parameter int NUM_RAILS   = 4,
   parameter int NUM_POK     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 2,
   parameter int EVT_LEN     = 4,
   parameter int RAIL_GAP    = 4,
   parameter int PG_DLY      = 64,
   parameter int POK_GAP     = 16,
   parameter int TIMEOUT     = 32768
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 btn_n_i,
   input  logic                 slp_lite_n_i,
   input  logic                 slp_deep_n_i,
   input  logic [NUM_PG-1:0]    pgood_i,
   output logic                 btn_evt_n_o,
   output logic [NUM_RAILS-1:0] rail_en_o,
   output logic [NUM_POK-1:0]   pok_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_seq_ctrl: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW < 1) begin : g_bad_low
      $error("pwr_seq_ctrl: MIN_LOW must be at least 1");
   end
   if (EVT_LEN < 2) begin : g_bad_evt
      $error("pwr_seq_ctrl: EVT_LEN must be at least 2");
   end
   if (NUM_RAILS < 2 || NUM_POK < 1 || NUM_PG < 1) begin : g_bad_width
      $error("pwr_seq_ctrl: rail, power-OK and power-good counts too small");
   end
   if (RAIL_GAP < 1 || TIMEOUT < 2 || PG_DLY < 0 || POK_GAP < 1) begin : g_bad_time
      $error("pwr_seq_ctrl: timing parameters out of range");
   end

   logic press;
   logic on;
   logic pg_all;

   assign pg_all = &pgood_i;

   pwr_seq_btn #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_LOW     (MIN_LOW),
      .EVT_LEN     (EVT_LEN)
   ) u_btn (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .btn_n_i (btn_n_i),
      .press_o (press),
      .evt_n_o (btn_evt_n_o)
   );

   pwr_seq_fsm #(
      .NUM_RAILS (NUM_RAILS),
      .RAIL_GAP  (RAIL_GAP),
      .TIMEOUT   (TIMEOUT)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .press_i      (press),
      .slp_lite_n_i (slp_lite_n_i),
      .slp_deep_n_i (slp_deep_n_i),
      .pg_all_i     (pg_all),
      .rails_o      (rail_en_o),
      .on_o         (on)
   );

   pwr_seq_pok #(
      .NUM_POK (NUM_POK),
      .PG_DLY  (PG_DLY),
      .POK_GAP (POK_GAP)
   ) u_pok (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (on),
      .pok_o  (pok_o)
   );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
   parameter int NUM_PG    = 4,
   parameter int NUM_RAILS = 4,
   parameter int NUM_POK   = 3
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 slp_deep_n_i,
   input logic [NUM_PG-1:0]    pgood_i,
   input logic                 btn_evt_n_o,
   input logic [NUM_RAILS-1:0] rail_en_o,
   input logic [NUM_POK-1:0]   pok_o
);

   a_r10_pok_needs_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pok_o) |-> (&rail_en_o));

   a_r6_pok_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pok_o >> 1) & ~pok_o) == '0);

   a_r5_rails_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rail_en_o >> 1) & ~rail_en_o) == '0);

   a_r7_fault_drops_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pok_o[0] && !(&pgood_i)) |=> (rail_en_o == '0 && pok_o == '0));

   a_r9_deep_sleep_pok_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pok_o[0] && (&pgood_i) && !slp_deep_n_i) |=> (pok_o == '0 && (&rail_en_o)));

   a_r4_stby_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_en_o[0]) |-> !btn_evt_n_o);

   a_r3_event_not_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(btn_evt_n_o) |=> !btn_evt_n_o);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
   .NUM_PG    (NUM_PG),
   .NUM_RAILS (NUM_RAILS),
   .NUM_POK   (NUM_POK)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .slp_deep_n_i (slp_deep_n_i),
   .pgood_i      (pgood_i),
   .btn_evt_n_o  (btn_evt_n_o),
   .rail_en_o    (rail_en_o),
   .pok_o        (pok_o)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

   localparam int NPG = 4;
   localparam int NR  = 4;
   localparam int NP  = 3;
   localparam int RG  = 3;
   localparam int DLY = 20;
   localparam int GAP = 6;
   localparam int TO  = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          btn_n = 1'b1;
   logic          slp_lite_n = 1'b0;
   logic          slp_deep_n = 1'b0;
   logic [NPG-1:0] pg = '0;
   logic          evt_n;
   logic [NR-1:0] rails;
   logic [NP-1:0] pok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_seq_ctrl #(
      .NUM_PG (NPG), .NUM_RAILS (NR), .NUM_POK (NP),
      .SYNC_STAGES (2), .MIN_LOW (2), .EVT_LEN (4),
      .RAIL_GAP (RG), .PG_DLY (DLY), .POK_GAP (GAP), .TIMEOUT (TO)
   ) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .btn_n_i (btn_n),
      .slp_lite_n_i (slp_lite_n), .slp_deep_n_i (slp_deep_n),
      .pgood_i (pg), .btn_evt_n_o (evt_n), .rail_en_o (rails), .pok_o (pok)
   );

   // Expected power-OK vector t edges after all power-good was first driven high.
   function automatic logic [NP-1:0] exp_pok(input int t);
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = (t >= 1 + DLY + i * GAP);
      return v;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_rails(input string tag, input logic [NR-1:0] e);
      check(rails === e, tag, 32'(rails), 32'(e));
   endtask

   task automatic chk_pok(input string tag, input logic [NP-1:0] e);
      check(pok === e, tag, 32'(pok), 32'(e));
   endtask

   // Drives the button low for n sampled cycles; returns at 4 edges after the fall.
   task automatic press(input int n);
      btn_n = 1'b0;
      tick(n);
      btn_n = 1'b1;
      tick(4 - n);
   endtask

   task automatic power_up(input int wait_slp);
      slp_lite_n = 1'b0; slp_deep_n = 1'b0; pg = '0;
      press(2);
      tick(wait_slp);
      slp_lite_n = 1'b1; slp_deep_n = 1'b1;
      tick(4 * RG - 2);
      pg = '1;
      tick(1 + DLY + 2 * GAP);
   endtask

   initial begin
      void'($urandom(32'd20140601));
      tick(3);
      // R1: reset state
      chk_rails("R1 rails in reset", '0);
      chk_pok("R1 pok in reset", '0);
      check(evt_n === 1'b1, "R1 event idle", 32'(evt_n), 1);
      rst_n = 1'b1;
      tick(3);

      // R2: single-cycle glitch ignored
      press(1);
      tick(8);
      chk_rails("R2 glitch ignored rails", '0);
      check(evt_n === 1'b1, "R2 glitch no event", 32'(evt_n), 1);

      // R2/R3/R4: accepted press
      press(2);
      chk_rails("R4 standby on press", 4'b0001);
      check(evt_n === 1'b0, "R3 event starts", 32'(evt_n), 0);
      tick(3);
      check(evt_n === 1'b0, "R3 event 4th cycle", 32'(evt_n), 0);
      tick(1);
      check(evt_n === 1'b1, "R3 event ends", 32'(evt_n), 1);
      tick($urandom_range(0, 40));
      chk_rails("R4 waiting for release", 4'b0001);
      slp_lite_n = 1'b1;
      tick(8);
      chk_rails("R4 one release not enough", 4'b0001);

      // R5: staged ramp
      slp_deep_n = 1'b1;
      tick(RG);
      chk_rails("R5 before suspend", 4'b0001);
      tick(1);
      chk_rails("R5 suspend", 4'b0011);
      tick(RG);
      chk_rails("R5 main", 4'b0111);
      tick(RG);
      chk_rails("R5 core", 4'b1111);

      // R6: staggered power-OK, every cycle
      pg = '1;
      for (int t = 1; t <= 1 + DLY + 2 * GAP + 3; t++) begin
         tick(1);
         chk_pok("R6 pok stagger", exp_pok(t));
      end

      // R9: shutdown by press
      btn_n = 1'b0;
      tick(2);
      btn_n = 1'b1;
      tick(1);
      chk_pok("R9 pok still up before press acts", 3'b111);
      tick(1);
      chk_pok("R9 pok dropped first", '0);
      chk_rails("R9 rails still on", 4'b1111);
      check(evt_n === 1'b0, "R3 shutdown press forwarded", 32'(evt_n), 0);
      tick(RG - 1);
      chk_rails("R9 core still on", 4'b1111);
      tick(1);
      chk_rails("R9 core off", 4'b0111);
      tick(RG);
      chk_rails("R9 main off", 4'b0011);
      tick(RG);
      chk_rails("R9 suspend off", 4'b0001);
      tick(RG);
      chk_rails("R9 standby off", 4'b0000);
      tick(6);

      // R9: shutdown by deep sleep
      power_up(3);
      chk_pok("R6 all pok up", 3'b111);
      slp_deep_n = 1'b0;
      tick(1);
      chk_pok("R9 deep sleep pok off", '0);
      chk_rails("R9 deep sleep rails on", 4'b1111);
      tick(RG);
      chk_rails("R9 deep core off", 4'b0111);
      tick(3 * RG);
      chk_rails("R9 deep all off", 4'b0000);
      tick(4);

      // R8: timeout waiting for sleep release
      slp_lite_n = 1'b0; slp_deep_n = 1'b0; pg = '0;
      press(2);
      chk_rails("R8 standby on", 4'b0001);
      tick(TO - 1);
      chk_rails("R8 just before timeout", 4'b0001);
      tick(1);
      chk_rails("R8 release timeout", 4'b0000);
      tick(4);

      // R8: timeout waiting for power-good
      press(2);
      slp_lite_n = 1'b1; slp_deep_n = 1'b1;
      tick(3 * RG + 1);
      chk_rails("R8 ramp done", 4'b1111);
      tick(TO - 1);
      chk_rails("R8 pg wait holds", 4'b1111);
      tick(1);
      chk_rails("R8 pg timeout", 4'b0000);
      chk_pok("R8 pok never rose", '0);
      tick(4);

      // R7: random power-good loss at random points
      for (int it = 0; it < 8; it++) begin
         int k;
         int bitn;
         k = $urandom_range(1, 1 + DLY + 2 * GAP + 4);
         bitn = $urandom_range(0, NPG - 1);
         slp_lite_n = 1'b0; slp_deep_n = 1'b0; pg = '0;
         press(2);
         tick($urandom_range(0, 20));
         slp_lite_n = 1'b1; slp_deep_n = 1'b1;
         tick(3 * RG + 1);
         pg = '1;
         for (int t = 1; t <= k; t++) begin
            tick(1);
            chk_pok("R6 random stagger", exp_pok(t));
         end
         pg[bitn] = 1'b0;
         tick(1);
         chk_rails("R7 rails off on pg loss", '0);
         chk_pok("R7 pok off on pg loss", '0);
         tick(5);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule